// File: doc/BRIEF.md
# Double-Data-Rate Output Register

A single-bit output stage that puts two data bits out in every clock period. The bit on `d_rise_i` is shown on `q_o` while the clock is high, and the bit on `d_fall_i` is shown while the clock is low. Holding `d_rise_i` at 1 and `d_fall_i` at 0 copies the clock onto `q_o`, so the same stage can forward a clock next to the data it goes with.

Three parameters set the variant. `CAP_MODE` chooses how the low-half bit is taken in. In opposite-edge mode it is sampled on the falling edge. In same-edge mode both bits are sampled on the rising edge and the low-half bit waits internally until the falling edge, so upstream logic only has to meet rising-edge timing. `INIT_VAL` sets the power-up output. `SR_KIND` chooses whether set and reset wait for a clock edge or act at once. A clock enable freezes all capture.

Top module: `ddr_out_reg`

## Requirements
- R1: While `clk_i` is high, `q_o` equals the stored rising-half bit; while `clk_i` is low, it equals the stored falling-half bit.
- R2: With `ce_i`=1, `d_rise_i`=1 and `d_fall_i`=0 held steady, `q_o` follows `clk_i` from the second rising edge onward.
- R3: With `CAP_MODE`=CAP_OPPOSITE, `d_rise_i` is sampled at each rising edge and `d_fall_i` at each falling edge. Each sampled value shows in the half-period that the sampling edge starts.
- R4: With `CAP_MODE`=CAP_SAME, both inputs are sampled at the rising edge. The `d_fall_i` sample shows in the low half that follows that same rising edge.
- R5: Before the first clock edge, and with set and reset idle, `q_o` equals `INIT_VAL`.
- R6: With `SR_KIND`=SR_SYNC, set and reset act on each half's own edge: the rising half changes at the next rising edge and the falling half at the next falling edge.
- R7: With `SR_KIND`=SR_ASYNC, asserting set or reset changes `q_o` at once, in the middle of a half-period.
- R8: `set_i`=1 and `rst_ni`=0 must never hold together, and an assertion flags it. Going straight from reset to set, or from set to reset, in one step gives the new value with no stale data bit in between.
- R9: While `ce_i`=0 and set/reset are idle, no data is captured and `q_o` keeps repeating the last captured pair. In same-edge mode a pair sampled at a rising edge is always shown complete.
- R10: While `rst_ni`=0, both halves read 0 once their edge has passed. While `set_i`=1, both halves read 1 under the same rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also selects which half is shown |
| rst_ni | input | 1 | Active-low reset of the output to 0 |
| set_i | input | 1 | Active-high set of the output to 1 |
| ce_i | input | 1 | Capture enable |
| d_rise_i | input | 1 | Bit shown while the clock is high |
| d_fall_i | input | 1 | Bit shown while the clock is low |
| q_o | output | 1 | Double-rate output |

## Verification
Two events can land in the same half-period: a data capture, and a set or reset that arrives partway through the half. The bench raises set or reset 0.5 ns after a falling or rising edge while capture is running. Four parameter variants share one stimulus, so the synchronous and asynchronous copies can be told apart in that half. `q_o` is sampled 1 ns after each edge and compared with a bench model. An asynchronous copy must already show the new level, and a synchronous copy must still show the data bit captured at that edge.

// File: rtl/ddr_out_pkg.sv
`timescale 1ns/1ps
package ddr_out_pkg;
  typedef enum logic { CAP_OPPOSITE = 1'b0, CAP_SAME = 1'b1 } cap_mode_e;
  typedef enum logic { SR_SYNC = 1'b0, SR_ASYNC = 1'b1 } sr_kind_e;
endpackage

// File: rtl/ddr_edge_flop.sv
`timescale 1ns/1ps
module ddr_edge_flop #(
  parameter bit                   NEG_EDGE = 1'b0,
  parameter ddr_out_pkg::sr_kind_e SR_KIND = ddr_out_pkg::SR_SYNC,
  parameter bit                   INIT_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  localparam bit ASYNC = (SR_KIND == ddr_out_pkg::SR_ASYNC);

  logic clk_e;
  logic q_q;

  assign clk_e = NEG_EDGE ? ~clk_i : clk_i;

  // power-up value, as a configured flop would load
  initial q_q = INIT_VAL;

  if (ASYNC) begin : g_async
    always @(posedge clk_e or negedge rst_ni or posedge set_i) begin
      if (!rst_ni)    q_q <= 1'b0;
      else if (set_i) q_q <= 1'b1;
      else if (en_i)  q_q <= d_i;
    end
  end else begin : g_sync
    always @(posedge clk_e) begin
      if (!rst_ni)    q_q <= 1'b0;
      else if (set_i) q_q <= 1'b1;
      else if (en_i)  q_q <= d_i;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/ddr_half_sel.sv
`timescale 1ns/1ps
module ddr_half_sel (
  input  logic clk_i,
  input  logic hi_i,
  input  logic lo_i,
  output logic q_o
);
  assign q_o = clk_i ? hi_i : lo_i;
endmodule

// File: rtl/ddr_out_reg.sv
`timescale 1ns/1ps
module ddr_out_reg #(
  parameter ddr_out_pkg::cap_mode_e CAP_MODE = ddr_out_pkg::CAP_OPPOSITE,
  parameter ddr_out_pkg::sr_kind_e  SR_KIND  = ddr_out_pkg::SR_SYNC,
  parameter bit                     INIT_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ce_i,
  input  logic d_rise_i,
  input  logic d_fall_i,
  output logic q_o
);
  localparam bit SAME = (CAP_MODE == ddr_out_pkg::CAP_SAME);

  logic q_rise;
  logic q_fall;
  logic fall_src;
  logic fall_en;

  ddr_edge_flop #(.NEG_EDGE(1'b0), .SR_KIND(SR_KIND), .INIT_VAL(INIT_VAL)) i_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i),
    .en_i(ce_i), .d_i(d_rise_i), .q_o(q_rise)
  );

  if (SAME) begin : g_same
    logic fall_hold;
    // low-half bit taken at the rising edge, moved over at the falling edge
    ddr_edge_flop #(.NEG_EDGE(1'b0), .SR_KIND(SR_KIND), .INIT_VAL(INIT_VAL)) i_hold (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i),
      .en_i(ce_i), .d_i(d_fall_i), .q_o(fall_hold)
    );
    assign fall_src = fall_hold;
    assign fall_en  = 1'b1;   // transfer always; gating already done at capture
  end else begin : g_opp
    assign fall_src = d_fall_i;
    assign fall_en  = ce_i;
  end

  ddr_edge_flop #(.NEG_EDGE(1'b1), .SR_KIND(SR_KIND), .INIT_VAL(INIT_VAL)) i_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i),
    .en_i(fall_en), .d_i(fall_src), .q_o(q_fall)
  );

  ddr_half_sel i_sel (
    .clk_i(clk_i), .hi_i(q_rise), .lo_i(q_fall), .q_o(q_o)
  );
endmodule

// File: rtl/ddr_out_reg_chk.sv
`timescale 1ns/1ps
module ddr_out_reg_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic set_i,
  input logic ce_i,
  input logic d_rise_i,
  input logic q_rise,
  input logic q_fall
);
  logic rst_seen;
  logic set_seen;

  initial begin
    rst_seen = 1'b0;
    set_seen = 1'b0;
  end

  always @(posedge clk_i) rst_seen <= !rst_ni;
  always @(negedge clk_i) set_seen <= set_i;

  // set and reset are mutually exclusive (R8)
  always @(posedge clk_i) begin
    assert_sr_exclusive_R8: assert (!(set_i && !rst_ni))
      else $error("set and reset asserted together");
  end

  // rising half cleared once reset has been seen at a rising edge (R10)
  always @(negedge clk_i) begin
    if (rst_seen && !rst_ni) begin
      assert_rst_rise_R10: assert (q_rise == 1'b0)
        else $error("rising half not cleared under reset");
    end
  end

  // falling half forced high once set has been seen at a falling edge (R10)
  always @(posedge clk_i) begin
    if (set_seen && set_i) begin
      assert_set_fall_R10: assert (q_fall == 1'b1)
        else $error("falling half not set");
    end
  end

  assert_rise_capture_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni || set_i)
    ce_i |=> (q_rise == $past(d_rise_i)));

  assert_ce_hold_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni || set_i)
    !ce_i |=> $stable(q_rise));
endmodule

bind ddr_out_reg ddr_out_reg_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .ce_i(ce_i),
  .d_rise_i(d_rise_i), .q_rise(q_rise), .q_fall(q_fall)
);

// File: tb/test_ddr_out_reg.sv
`timescale 1ns/1ps
module test_ddr_out_reg;
  localparam int NCFG = 4;
  // per-variant settings: bit k belongs to variant k
  localparam bit [NCFG-1:0] CFG_SAME  = 4'b0110;
  localparam bit [NCFG-1:0] CFG_ASYNC = 4'b1010;
  localparam bit [NCFG-1:0] CFG_INIT  = 4'b1100;

  logic clk   = 1'b0;
  logic rst_n = 1'b1;
  logic set   = 1'b0;
  logic ce    = 1'b0;
  logic d_r   = 1'b0;
  logic d_f   = 1'b0;

  wire [NCFG-1:0] q;
  wire [NCFG-1:0] exp_r;
  wire [NCFG-1:0] exp_f;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  bit    fwd   = 1'b0;
  string cur_req = "R5";

  always #2 clk = ~clk;   // 250 MHz

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    ddr_out_reg #(
      .CAP_MODE(ddr_out_pkg::cap_mode_e'(CFG_SAME[k])),
      .SR_KIND (ddr_out_pkg::sr_kind_e'(CFG_ASYNC[k])),
      .INIT_VAL(CFG_INIT[k])
    ) i_ddr_out_reg (
      .clk_i(clk), .rst_ni(rst_n), .set_i(set), .ce_i(ce),
      .d_rise_i(d_r), .d_fall_i(d_f), .q_o(q[k])
    );

    // reference model written from the requirements
    logic mr = CFG_INIT[k];
    logic mh = CFG_INIT[k];
    logic mf = CFG_INIT[k];

    if (CFG_ASYNC[k]) begin : g_ma
      always @(posedge clk or negedge rst_n or posedge set) begin
        if (!rst_n)   begin mr <= 1'b0; mh <= 1'b0; end
        else if (set) begin mr <= 1'b1; mh <= 1'b1; end
        else if (ce)  begin mr <= d_r;  mh <= d_f;  end
      end
      always @(negedge clk or negedge rst_n or posedge set) begin
        if (!rst_n)             mf <= 1'b0;
        else if (set)           mf <= 1'b1;
        else if (CFG_SAME[k])   mf <= mh;
        else if (ce)            mf <= d_f;
      end
    end else begin : g_ms
      always @(posedge clk) begin
        if (!rst_n)   begin mr <= 1'b0; mh <= 1'b0; end
        else if (set) begin mr <= 1'b1; mh <= 1'b1; end
        else if (ce)  begin mr <= d_r;  mh <= d_f;  end
      end
      always @(negedge clk) begin
        if (!rst_n)             mf <= 1'b0;
        else if (set)           mf <= 1'b1;
        else if (CFG_SAME[k])   mf <= mh;
        else if (ce)            mf <= d_f;
      end
    end
    assign exp_r[k] = mr;
    assign exp_f[k] = mf;
  end

  task automatic check_bit(string req, int k, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s variant=%0d t=%0t actual=%b expected=%b", req, k, $time, act, exp);
    end
  endtask

  task automatic sample(logic hi);
    for (int k = 0; k < NCFG; k++) begin
      if (fwd) check_bit("R2", k, q[k], hi);
      else     check_bit(cur_req, k, q[k], hi ? exp_r[k] : exp_f[k]);
    end
  endtask

  always @(posedge clk) begin #1; if (!done) sample(1'b1); end
  always @(negedge clk) begin #1; if (!done) sample(1'b0); end

  task automatic drv();
    @(posedge clk);
    #0.5;
  endtask

  task automatic drv_neg();
    @(negedge clk);
    #0.5;
  endtask

  task automatic rand_data();
    d_r = 1'($urandom_range(0, 1));
    d_f = 1'($urandom_range(0, 1));
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R5: power-up value before any edge
    #1;
    for (int k = 0; k < NCFG; k++) check_bit("R5", k, q[k], CFG_INIT[k]);
    drv();
    drv();

    // R10: reset clears both halves
    cur_req = "R10 reset";
    rst_n = 1'b0;
    repeat (3) drv();
    rst_n = 1'b1;
    drv();

    // R1 R3 R4: free-running capture with random data
    cur_req = "R1 R3 R4";
    ce = 1'b1;
    for (int i = 0; i < 60; i++) begin rand_data(); drv(); end

    // R9: enable toggling freezes the last pair
    cur_req = "R9";
    for (int i = 0; i < 80; i++) begin
      ce = ($urandom_range(0, 2) == 0);
      rand_data();
      drv();
    end

    // R2: clock forwarding pattern
    cur_req = "R2 fill";
    ce = 1'b1; d_r = 1'b1; d_f = 1'b0;
    @(posedge clk);
    fwd = 1'b1;
    repeat (20) @(posedge clk);
    fwd = 1'b0;
    #0.5;

    // R10: set drives both halves high
    cur_req = "R10 set";
    rand_data();
    set = 1'b1;
    repeat (3) drv();
    set = 1'b0;
    drv();

    // R6 R7: set/reset arriving mid-half while capture runs
    cur_req = "R6 R7";
    for (int i = 0; i < 6; i++) begin
      rand_data();
      drv();
      rst_n = 1'b0;
      drv();
      rst_n = 1'b1;
      rand_data();
      drv();
      drv_neg();
      set = 1'b1;
      drv();
      set = 1'b0;
      rand_data();
      drv_neg();
      rst_n = 1'b0;
      drv();
      rst_n = 1'b1;
      rand_data();
      drv();
    end

    // R8: direct hand-over between reset and set
    cur_req = "R8";
    rst_n = 1'b0;
    drv();
    drv();
    rst_n = 1'b1; set = 1'b1;
    drv();
    drv();
    set = 1'b0; rst_n = 1'b0;
    drv();
    rst_n = 1'b1;
    rand_data();
    drv();

    // mixed random traffic
    cur_req = "R1 R3 R4 R9 R10";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 19);
      set   = 1'b0;
      rst_n = (r != 0);
      set   = (r == 1);
      ce    = ($urandom_range(0, 3) != 0);
      rand_data();
      if (r == 2) drv_neg(); else drv();
    end
    set = 1'b0; rst_n = 1'b1;
    drv();
    drv();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule